// File: doc/BRIEF.md
# Adaptive Two-Stage Noise-Shaping Combiner

This block is the digital back end of a two-stage cascaded time-to-digital converter built from free-running oscillators. On every sampling strobe it receives three counts: the total count of the first stage, the part of that count taken while the first stage ran in its fast mode (the off-time count), and the total count of the second stage. It merges them into one output word in which the first-stage quantisation error is cancelled. What remains is second-order shaped quantisation noise.

Cancellation needs a weight equal to the ratio between the second stage's mode-frequency difference and the first stage's fast-mode frequency. Mismatch between the oscillators of the two stages makes this ratio unknown, and it can be off by more than a third. The block therefore learns the weight online with a single-tap least-mean-squares loop. The same learned weight corrects the second-stage count and scales the first-stage term. A freeze input stops the learning while output words keep flowing. The initial weight is loaded from a port at reset.

Top module: `mash_lms_combiner`

## Requirements
- R1: While `rst` is high on a clock edge, `out_valid` goes to 0, `out_word` goes to 0, `coef` takes the value of `w_init`, and no earlier sample is remembered.
- R2: The weight `coef` is a signed 16-bit value with 14 fraction bits, so 16384 means 1.0. Each sample forms a corrected second-stage value C = `d2`·16384 − `coef`·`d1f`, an integer in units of 2^-14 counts. The counts are unsigned.
- R3: For a sample that has a previous sample since reset, the output is Y = −`coef`·`d1` − (C_now − C_prev). It is a signed `CNT_W`+19-bit word with 14 fraction bits, and `out_word` shows it one clock after the strobe.
- R4: `out_valid` is high for exactly the clock after an `in_valid` cycle that had a previous sample. The first sample after reset gives no output.
- R5: On each sample with output and `freeze` low, the weight becomes `coef` + ((Y·`d1`) >>> `MU_SHIFT`), shifted arithmetically with rounding toward minus infinity. The new weight shows on `coef` one clock after the strobe. The first sample after reset leaves the weight unchanged.
- R6: When the weight update would go above 32767 or below −32768, it clamps to that limit instead of wrapping.
- R7: With `freeze` high, the weight stays unchanged while output words are still produced per R3 and R4.
- R8: In a cycle without `in_valid`, `coef` and `out_word` keep their values and `out_valid` is 0.
- R9: The stored C_prev is computed with the weight that was in force when its own sample arrived. It is not recomputed after the weight changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| w_init | input | 16 | Signed weight loaded at reset (14 fraction bits) |
| freeze | input | 1 | Holds the weight when high |
| in_valid | input | 1 | Strobe marking a new set of counts |
| d1 | input | CNT_W | First-stage total count |
| d1f | input | CNT_W | First-stage off-time count |
| d2 | input | CNT_W | Second-stage total count |
| out_valid | output | 1 | High one clock after a sample that yields an output |
| out_word | output | CNT_W+19 | Signed combined output word, 14 fraction bits |
| coef | output | 16 | Current signed weight, 14 fraction bits |

## Verification
The output word and the updated weight both come out of a single register stage, so both are due at the first rising edge after the strobe cycle and stay put until the next strobe. The bench changes inputs on falling edges and reads `out_valid`, `out_word` and `coef` on the following falling edge. Each reading therefore shows exactly one sample's effect. The bench also keeps its own record of the weight and of the previous corrected value, so the order of the weight change and of C_prev (R9) is checked in that same cycle. Idle cycles are read on further falling edges to confirm that nothing moves without a strobe.

// File: rtl/mash_lms_pkg.sv
package mash_lms_pkg;

    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;
    localparam int COEF_MAX  = 32767;
    localparam int COEF_MIN  = -32768;

    typedef logic signed [COEF_W-1:0] coef_t;

    typedef enum logic [1:0] {
        CA_HOLD = 2'd0,
        CA_LOAD = 2'd1,
        CA_STEP = 2'd2
    } coef_act_e;

    // Clamp a wide signed sum into the weight range.
    function automatic coef_t sat_coef(input logic signed [63:0] v);
        if (v > 64'sd32767)
            return coef_t'(COEF_MAX);
        else if (v < -64'sd32768)
            return coef_t'(COEF_MIN);
        else
            return coef_t'(v[COEF_W-1:0]);
    endfunction

endpackage

// File: rtl/mash_combine.sv
module mash_combine
    import mash_lms_pkg::*;
#(
    parameter int CW = 8,
    parameter int YW = CW + 19
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [CW-1:0]        d1,
    input  logic [CW-1:0]        d1f,
    input  logic [CW-1:0]        d2,
    input  coef_t                coef,
    output logic signed [YW-1:0] y,
    output logic signed [CW:0]   regr,
    output logic                 hist_ok
);

    localparam int DW = YW - 1;

    logic signed [DW-1:0] coef_x;
    logic signed [DW-1:0] d1_x;
    logic signed [DW-1:0] d1f_x;
    logic signed [DW-1:0] d2_x;
    logic signed [DW-1:0] w_d1;
    logic signed [DW-1:0] w_d1f;
    logic signed [DW-1:0] corr_now;
    logic signed [DW-1:0] corr_prev;

    always_comb begin
        coef_x   = {{(DW-COEF_W){coef[COEF_W-1]}}, coef};
        d1_x     = {{(DW-CW){1'b0}}, d1};
        d1f_x    = {{(DW-CW){1'b0}}, d1f};
        d2_x     = {{(DW-CW){1'b0}}, d2};
        w_d1     = coef_x * d1_x;
        w_d1f    = coef_x * d1f_x;
        corr_now = (d2_x <<< COEF_FRAC) - w_d1f;
        y        = -{w_d1[DW-1], w_d1}
                   - ({corr_now[DW-1], corr_now} - {corr_prev[DW-1], corr_prev});
        regr     = {1'b0, d1};
    end

    // One sample of history for the first difference of the corrected term.
    always_ff @(posedge clk) begin
        if (rst) begin
            corr_prev <= '0;
            hist_ok   <= 1'b0;
        end else if (in_valid) begin
            corr_prev <= corr_now;
            hist_ok   <= 1'b1;
        end
    end

    AST_HIST_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(hist_ok) |-> $past(in_valid)) else $error("history without sample"); // R4

    AST_HIST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(corr_prev)) else $error("history moved while idle"); // R9

endmodule

// File: rtl/mash_coef_reg.sv
module mash_coef_reg
    import mash_lms_pkg::*;
#(
    parameter int EW       = 27,
    parameter int XW       = 9,
    parameter int MU_SHIFT = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  coef_t                w_init,
    input  logic                 step_en,
    input  logic                 freeze,
    input  logic signed [EW-1:0] err,
    input  logic signed [XW-1:0] regr,
    output coef_t                coef
);

    localparam int PW = EW + XW;
    localparam int SW = PW + 1;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] delta;
    logic signed [SW-1:0] sum;
    coef_t                stepped;
    coef_act_e            act;

    always_comb begin
        prod    = {{XW{err[EW-1]}}, err} * {{EW{regr[XW-1]}}, regr};
        delta   = prod >>> MU_SHIFT;
        sum     = {delta[PW-1], delta} + {{(SW-COEF_W){coef[COEF_W-1]}}, coef};
        stepped = sat_coef({{(64-SW){sum[SW-1]}}, sum});
        if (rst)
            act = CA_LOAD;
        else if (step_en && !freeze)
            act = CA_STEP;
        else
            act = CA_HOLD;
    end

    always_ff @(posedge clk) begin
        unique case (act)
            CA_LOAD: coef <= w_init;
            CA_STEP: coef <= stepped;
            default: coef <= coef;
        endcase
    end

    AST_RESET_LOADS_INIT: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> coef == $past(w_init)) else $error("reset weight wrong"); // R1

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(coef)) else $error("weight moved while frozen"); // R7

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (step_en && !freeze && sum > SW'(COEF_MAX)) |=> coef == coef_t'(COEF_MAX))
        else $error("weight did not clamp high"); // R6

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
        (step_en && !freeze && sum < -SW'(32768)) |=> coef == coef_t'(COEF_MIN))
        else $error("weight did not clamp low"); // R6

endmodule

// File: rtl/mash_lms_combiner.sv
module mash_lms_combiner
    import mash_lms_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int MU_SHIFT = 10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic signed [15:0]        w_init,
    input  logic                      freeze,
    input  logic                      in_valid,
    input  logic [CNT_W-1:0]          d1,
    input  logic [CNT_W-1:0]          d1f,
    input  logic [CNT_W-1:0]          d2,
    output logic                      out_valid,
    output logic signed [CNT_W+18:0]  out_word,
    output logic signed [15:0]        coef
);

    localparam int YW = CNT_W + 19;
    localparam int XW = CNT_W + 1;

    logic signed [YW-1:0] y;
    logic signed [XW-1:0] regr;
    logic                 hist_ok;
    logic                 produce;
    coef_t                coef_q;

    assign produce = in_valid && hist_ok;
    assign coef    = coef_q;

    mash_combine #(
        .CW (CNT_W),
        .YW (YW)
    ) u_combine (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .d1       (d1),
        .d1f      (d1f),
        .d2       (d2),
        .coef     (coef_q),
        .y        (y),
        .regr     (regr),
        .hist_ok  (hist_ok)
    );

    mash_coef_reg #(
        .EW       (YW),
        .XW       (XW),
        .MU_SHIFT (MU_SHIFT)
    ) u_coef (
        .clk     (clk),
        .rst     (rst),
        .w_init  (w_init),
        .step_en (produce),
        .freeze  (freeze),
        .err     (y),
        .regr    (regr),
        .coef    (coef_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= produce;
            if (produce)
                out_word <= y;
        end
    end

    AST_VALID_LAGS_STROBE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)) else $error("output without strobe"); // R4

    AST_IDLE_COEF_STABLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(coef) && !out_valid) else $error("change while idle"); // R8

    AST_IDLE_WORD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !produce |=> $stable(out_word)) else $error("word moved without output"); // R8

endmodule

// File: tb/tb_mash_lms_combiner.sv
module tb_mash_lms_combiner;

    localparam int  CW       = 8;
    localparam int  MU       = 10;
    localparam int  YW       = CW + 19;
    localparam time CLK_HALF = 5;
    localparam time CLK_PER  = 2 * CLK_HALF;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic signed [15:0]     w_init = '0;
    logic                   freeze = 1'b0;
    logic                   in_valid = 1'b0;
    logic [CW-1:0]          d1 = '0;
    logic [CW-1:0]          d1f = '0;
    logic [CW-1:0]          d2 = '0;
    logic                   out_valid;
    logic signed [YW-1:0]   out_word;
    logic signed [15:0]     coef;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;

    longint m_w;
    longint m_prev;
    bit     m_hist;
    longint m_word;
    int unsigned lfsr = 32'h1234_5678;

    always #(CLK_HALF) clk = ~clk;

    mash_lms_combiner #(
        .CNT_W    (CW),
        .MU_SHIFT (MU)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .w_init    (w_init),
        .freeze    (freeze),
        .in_valid  (in_valid),
        .d1        (d1),
        .d1f       (d1f),
        .d2        (d2),
        .out_valid (out_valid),
        .out_word  (out_word),
        .coef      (coef)
    );

    function automatic longint clampw(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int unsigned next_rand(input int unsigned s);
        int unsigned t = s;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input longint init);
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        freeze   = 1'b0;
        w_init   = 16'(init);
        @(negedge clk);
        @(negedge clk);
        rst    = 1'b0;
        m_w    = init;
        m_hist = 1'b0;
        m_prev = 0;
        m_word = 0;
        check("R1", "out_valid after reset", longint'(out_valid), 0);
        check("R1", "out_word after reset", longint'(out_word), 0);
        check("R1", "coef after reset", longint'(coef), init);
    endtask

    // Drive one sample at a falling edge, read the result at the next one.
    task automatic send(input int a, input int af, input int b, input bit frz, input string req);
        longint corr;
        longint y;
        bit     exp_v;
        d1       = CW'(a);
        d1f      = CW'(af);
        d2       = CW'(b);
        freeze   = frz;
        in_valid = 1'b1;
        corr = longint'(b) * 16384 - m_w * longint'(af);
        exp_v = m_hist;
        if (m_hist) begin
            y = -m_w * longint'(a) - (corr - m_prev);
            m_word = y;
            if (!frz)
                m_w = clampw(m_w + ((y * longint'(a)) >>> MU));
        end
        m_prev = corr;
        m_hist = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid", longint'(out_valid), longint'(exp_v));
        check(req, "out_word", longint'(out_word), m_word);
        check(req, "coef", longint'(coef), m_w);
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int vals[6] = '{0, 1, 127, 128, 254, 255};

        // R1 reset state with a nominal weight near 0.61
        do_reset(9994);

        // R4 first sample produces nothing, R2 R3 R5 R9 on a random stream
        send(100, 40, 90, 1'b0, "R4");
        for (int i = 0; i < 300; i++) begin
            lfsr = next_rand(lfsr);
            send(int'(lfsr[7:0]), int'(lfsr[15:8]), int'(lfsr[23:16]), 1'b0, "R3");
        end

        // R7 freeze: outputs keep coming, weight stays
        for (int i = 0; i < 50; i++) begin
            lfsr = next_rand(lfsr);
            send(int'(lfsr[7:0]), int'(lfsr[15:8]), int'(lfsr[23:16]), 1'b1, "R7");
        end

        // R8 idle cycles leave everything in place
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R8", "out_valid idle", longint'(out_valid), 0);
            check("R8", "out_word idle", longint'(out_word), m_word);
            check("R8", "coef idle", longint'(coef), m_w);
        end

        // R2 R5 R9 sweep over corner count values, small weight
        do_reset(1000);
        foreach (vals[i])
            foreach (vals[j])
                foreach (vals[k])
                    send(vals[i], vals[j], vals[k], 1'b0, "R2");

        // R6 clamp high
        do_reset(32000);
        send(1, 0, 255, 1'b0, "R6");
        send(1, 0, 0, 1'b0, "R6");
        check("R6", "coef clamped high", longint'(coef), 32767);

        // R6 clamp low
        do_reset(-32000);
        send(1, 0, 0, 1'b0, "R6");
        send(1, 0, 255, 1'b0, "R6");
        check("R6", "coef clamped low", longint'(coef), -32768);

        // R9 history kept across a weight change, then frozen step
        do_reset(-5000);
        send(10, 3, 20, 1'b0, "R9");
        send(200, 7, 5, 1'b0, "R9");
        send(3, 250, 250, 1'b1, "R9");
        send(0, 0, 0, 1'b0, "R9");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule